// File: doc/BRIEF.md
# Polyphase Analysis Filter Bank Front End

This block is the filtering half of a critically sampled channelizer. It takes one real sample stream and splits it into NUM_LEGS (default 8) parallel sub-filter legs. Each leg is a short FIR whose taps are a decimated slice of one low-pass prototype filter. A commutator hands every accepted input sample to exactly one leg. After each group of NUM_LEGS accepted samples, the block presents all leg results together as one wide vector. That vector is meant to feed a single NUM_LEGS-point FFT, so each vector yields one spectral snapshot of NUM_LEGS channels.

The leg results are never added together, and no leg is transformed on its own. The output is held by a valid/ready handshake. If the downstream stage still holds the previous vector when the next group is one sample from completing, the block withdraws `in_ready` until the old vector is taken.

Top module: `polyphase_chan_front`

## Requirements
- R1: A synchronous active-high `rst` clears all delay lines to zero, drops `out_valid`, and points the commutator at leg NUM_LEGS-1. After reset, `in_ready` is high.
- R2: Exactly one output vector is produced for every NUM_LEGS accepted samples. `out_valid` rises on the clock edge that accepts the NUM_LEGS-th sample of a group, and it stays low before that edge.
- R3: Within a group, the j-th accepted sample (j = 0 .. NUM_LEGS-1) goes to leg NUM_LEGS-1-j. The newest sample of a group therefore lands in leg 0.
- R4: Leg p outputs y_p(m) = sum over k = 0..TAPS-1 of h(p + k*NUM_LEGS) * x(( m-k)*NUM_LEGS + NUM_LEGS-1-p), where m is the group index and x(i) is the i-th accepted sample. Samples before reset count as zero.
- R5: The prototype coefficient is h(n) = 1000*((7*n) mod 13) - 6000 for n = 0 .. NUM_LEGS*TAPS-1. It is computed by a synthesizable constant function.
- R6: Leg results are kept separate. Leg p occupies `out_data[p*ACC_W +: ACC_W]` as a two's complement value.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged on the next cycle.
- R8: `in_ready` is low exactly when the commutator points at leg 0, `out_valid` is high and `out_ready` is low. A sample offered while `in_ready` is low is not consumed and changes no leg.
- R9: A cycle with `in_valid` low neither advances the commutator nor shifts any delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is offered |
| in_ready | output | 1 | Block can take the offered sample |
| in_data | input | IN_W (16) | Signed real input sample |
| out_valid | output | 1 | Output vector is held |
| out_ready | input | 1 | Downstream takes the vector |
| out_data | output | NUM_LEGS*ACC_W (288) | Packed per-leg results, leg p at bits p*ACC_W |

## Verification
The bench goes after the commutator order with an impulse placed at the start of a group. A design that fills legs in ascending order puts the coefficient product in leg 0 instead of leg 7. The bench then holds back `out_ready` across a full group to force the input stall. A design that forgets to stall overwrites the held vector, and a design that consumes a sample while `in_ready` is low shifts the whole commutator phase, so every later vector mismatches. Random gaps in `in_valid`, combined with a tone and random data, expose delay lines that shift on idle cycles or on other legs' samples, and they also expose a sum of legs in place of a per-leg vector.

// File: rtl/chan_pkg.sv
`timescale 1ns/1ps
package chan_pkg;
   // Prototype low-pass stand-in: h(n) = 1000*((7n) mod 13) - 6000
   function automatic int proto_coef(input int n);
      return 1000 * ((7 * n) % 13) - 6000;
   endfunction
endpackage

// File: rtl/chan_commutator.sv
`timescale 1ns/1ps
module chan_commutator #(
   parameter int NUM_LEGS = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                push,
   output logic [NUM_LEGS-1:0] leg_sel,
   output logic                last
);
   localparam int IDX_W = (NUM_LEGS > 1) ? $clog2(NUM_LEGS) : 1;
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_LEGS - 1);

   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx <= TOP_IDX;
      end else if (push) begin
         idx <= (idx == '0) ? TOP_IDX : idx - 1'b1;
      end
   end

   for (genvar p = 0; p < NUM_LEGS; p++) begin : g_sel
      assign leg_sel[p] = (idx == IDX_W'(p));
   end

   assign last = (idx == '0);

   // Descending fill within a group
   assert_desc_order_R3: assert property (@(posedge clk) disable iff (rst)
      push && !last |=> idx == $past(idx) - 1'b1);
   // Group wraps back to the top leg
   assert_group_wrap_R2: assert property (@(posedge clk) disable iff (rst)
      push && last |=> idx == TOP_IDX);
   // No advance without a push
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !push |=> $stable(idx));
endmodule

// File: rtl/chan_coef_rom.sv
`timescale 1ns/1ps
module chan_coef_rom #(
   parameter int NUM_LEGS = 8,
   parameter int TAPS     = 4,
   parameter int COEF_W   = 16,
   parameter int LEG      = 0
) (
   output logic signed [COEF_W-1:0] coef [TAPS]
);
   import chan_pkg::*;

   if (COEF_W < 14) begin : g_bad_w
      $error("COEF_W too narrow for prototype range");
   end
   if (LEG >= NUM_LEGS) begin : g_bad_leg
      $error("LEG out of range");
   end

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      localparam int VAL = proto_coef(LEG + k * NUM_LEGS);
      assign coef[k] = COEF_W'(VAL);
   end
endmodule

// File: rtl/chan_leg.sv
`timescale 1ns/1ps
module chan_leg #(
   parameter int NUM_LEGS = 8,
   parameter int TAPS     = 4,
   parameter int IN_W     = 16,
   parameter int COEF_W   = 16,
   parameter int ACC_W    = 36,
   parameter int LEG      = 0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    shift,
   input  logic signed [IN_W-1:0]  sample,
   output logic signed [ACC_W-1:0] acc
);
   localparam int PROD_W = IN_W + COEF_W;

   logic signed [IN_W-1:0]   line [TAPS];
   logic signed [IN_W-1:0]   view [TAPS];
   logic signed [COEF_W-1:0] coef [TAPS];
   logic signed [PROD_W-1:0] prod [TAPS];

   chan_coef_rom #(
      .NUM_LEGS(NUM_LEGS), .TAPS(TAPS), .COEF_W(COEF_W), .LEG(LEG)
   ) rom_i (
      .coef(coef)
   );

   // Per-leg delay line, shifts only on this leg's own sample
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < TAPS; k++) line[k] <= '0;
      end else if (shift) begin
         line[0] <= sample;
         for (int k = 1; k < TAPS; k++) line[k] <= line[k-1];
      end
   end

   // Look-ahead view: includes the sample arriving this cycle
   for (genvar k = 0; k < TAPS; k++) begin : g_view
      if (k == 0) begin : g_head
         assign view[k] = shift ? sample : line[0];
      end else begin : g_body
         assign view[k] = shift ? line[k-1] : line[k];
      end
      assign prod[k] = view[k] * coef[k];
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS; k++) begin
         acc = acc + ACC_W'(prod[k]);
      end
   end

   // Newest tap takes the pushed sample
   assert_tap_load_R3: assert property (@(posedge clk) disable iff (rst)
      shift |=> line[0] == $past(sample));
   // Idle leg keeps its history
   assert_line_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !shift |=> $stable(line[0]) && $stable(line[TAPS-1]));
endmodule

// File: rtl/polyphase_chan_front.sv
`timescale 1ns/1ps
module polyphase_chan_front #(
   parameter int NUM_LEGS = 8,
   parameter int TAPS     = 4,
   parameter int IN_W     = 16,
   parameter int COEF_W   = 16,
   parameter int ACC_W    = 36
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic signed [IN_W-1:0]      in_data,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [NUM_LEGS*ACC_W-1:0]   out_data
);
   localparam int VEC_W = NUM_LEGS * ACC_W;
   localparam int GROW  = (TAPS > 1) ? $clog2(TAPS) : 0;

   if (NUM_LEGS < 2) begin : g_bad_legs
      $error("NUM_LEGS must be at least 2");
   end
   if (TAPS < 1) begin : g_bad_taps
      $error("TAPS must be at least 1");
   end
   if (ACC_W < IN_W + COEF_W + GROW) begin : g_bad_acc
      $error("ACC_W cannot hold a full leg sum");
   end

   logic                    push;
   logic                    last;
   logic [NUM_LEGS-1:0]     leg_sel;
   logic signed [ACC_W-1:0] leg_acc [NUM_LEGS];
   logic [VEC_W-1:0]        vec_next;

   assign in_ready = !(last && out_valid && !out_ready);
   assign push     = in_valid && in_ready;

   chan_commutator #(.NUM_LEGS(NUM_LEGS)) comm_i (
      .clk(clk), .rst(rst), .push(push), .leg_sel(leg_sel), .last(last)
   );

   for (genvar p = 0; p < NUM_LEGS; p++) begin : g_leg
      chan_leg #(
         .NUM_LEGS(NUM_LEGS), .TAPS(TAPS), .IN_W(IN_W),
         .COEF_W(COEF_W), .ACC_W(ACC_W), .LEG(p)
      ) leg_i (
         .clk(clk), .rst(rst), .shift(push && leg_sel[p]),
         .sample(in_data), .acc(leg_acc[p])
      );
      assign vec_next[p*ACC_W +: ACC_W] = leg_acc[p];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (push && last) begin
         out_valid <= 1'b1;
         out_data  <= vec_next;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> !out_valid && in_ready);
   assert_hold_vec_R7: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
   assert_stall_cause_R8: assert property (@(posedge clk) disable iff (rst)
      !in_ready |-> out_valid && !out_ready);
   assert_valid_source_R2: assert property (@(posedge clk) disable iff (rst)
      !out_valid ##1 out_valid |-> $past(push) && $past(last));
endmodule

// File: tb/polyphase_chan_front_tb_top.sv
`timescale 1ns/1ps
module polyphase_chan_front_tb_top;
   localparam int D     = 8;
   localparam int T     = 4;
   localparam int AW    = 36;
   localparam int MAXS  = 4096;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic signed [15:0] in_data = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [D*AW-1:0]   out_data;

   polyphase_chan_front dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int hist [MAXS];
   int nsamp = 0;
   int pos = 0;
   logic [D*AW-1:0] expq [64];
   int qh = 0, qt = 0;
   bit held = 0;
   logic [D*AW-1:0] held_data;

   function automatic longint coef_h(input int n);
      return longint'(1000 * ((7 * n) % 13) - 6000);
   endfunction

   function automatic longint leg_val(input logic [D*AW-1:0] v, input int p);
      logic signed [AW-1:0] s;
      s = v[p*AW +: AW];
      return longint'(s);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Reference: direct decimated FIR per leg (R3, R4, R5)
   task automatic model_group(input int m);
      logic [D*AW-1:0] v;
      for (int p = 0; p < D; p++) begin
         longint s = 0;
         logic signed [AW-1:0] t;
         for (int k = 0; k < T; k++) begin
            if (m - k >= 0) s += coef_h(p + k * D) * longint'(hist[(m - k) * D + D - 1 - p]);
         end
         t = AW'(s);
         v[p*AW +: AW] = t;
      end
      expq[qt % 64] = v;
      qt++;
   endtask

   task automatic cycle(input bit v, input logic signed [15:0] d, input bit r);
      bit exp_rdy, acc;
      @(negedge clk);
      in_valid = v; in_data = d; out_ready = r;
      #1;
      exp_rdy = !(pos == D - 1 && out_valid && !out_ready);
      check(in_ready == exp_rdy, "R8 in_ready", longint'(in_ready), longint'(exp_rdy));
      if (held) begin
         check(out_valid && out_data == held_data, "R7 hold", longint'(out_valid), 1);
      end
      if (out_valid && out_ready) begin
         if (qh == qt) begin
            check(0, "R2 unexpected vector", 1, 0);
         end else begin
            for (int p = 0; p < D; p++) begin
               if (leg_val(out_data, p) != leg_val(expq[qh % 64], p))
                  $display("  leg %0d mismatch (R4 R6)", p);
            end
            check(out_data == expq[qh % 64], "R4 R6 vector", leg_val(out_data, 0),
                  leg_val(expq[qh % 64], 0));
            qh++;
         end
      end
      held = out_valid && !out_ready;
      held_data = out_data;
      acc = v && in_ready;
      @(posedge clk);
      if (acc) begin
         hist[nsamp] = int'(d);
         nsamp++;
         pos++;
         if (pos == D) begin
            pos = 0;
            model_group(nsamp / D - 1);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20080821));
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      #1;
      check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
      check(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);

      // Impulse at the first slot of a group -> leg 7 (R3, R5, R2)
      for (int i = 0; i < D; i++) begin
         cycle(1'b1, (i == 0) ? 16'sd1000 : 16'sd0, 1'b0);
         #1;
         if (i < D - 1) check(out_valid == 1'b0, "R2 early valid", longint'(out_valid), 0);
      end
      check(out_valid == 1'b1, "R2 valid after group", longint'(out_valid), 1);
      check(leg_val(out_data, 7) == 64'sd4000000, "R5 R3 leg7 coef", leg_val(out_data, 7), 4000000);
      check(leg_val(out_data, 0) == 0, "R3 leg0 empty", leg_val(out_data, 0), 0);
      for (int i = 0; i < 4 * D; i++) cycle(1'b1, 16'sd0, 1'b1);

      // Impulse at the last slot, with idle gaps (R3, R9)
      for (int i = 0; i < 3 * D; i++) begin
         cycle(1'b0, 16'sd777, 1'b1);
         cycle(1'b1, (i == D - 1) ? -16'sd2000 : 16'sd0, 1'b1);
      end
      for (int i = 0; i < 3 * D; i++) cycle(1'b1, 16'sd0, 1'b1);

      // Tone
      for (int i = 0; i < 12 * D; i++) begin
         real ph;
         ph = 2.0 * 3.14159265358979 * 3.0 * real'(i) / 32.0;
         cycle(1'b1, 16'($rtoi(8000.0 * $sin(ph))), 1'b1);
      end

      // Long stall: downstream blocked across a full group (R8, R7)
      for (int i = 0; i < 3 * D; i++) cycle(1'b1, 16'(i * 97 - 900), 1'b0);
      #1;
      check(in_ready == 1'b0, "R8 stalled", longint'(in_ready), 0);
      for (int i = 0; i < 4; i++) cycle(1'b1, 16'sd12345, 1'b0);
      for (int i = 0; i < 4 * D; i++) cycle(1'b1, 16'sd0, 1'b1);

      // Random data, random gaps, random backpressure
      for (int i = 0; i < 1500; i++) begin
         bit v, r;
         v = ($urandom % 4) != 0;
         r = ($urandom % 2) != 0;
         cycle(v, 16'($urandom), r);
      end
      for (int i = 0; i < 2 * D; i++) cycle(1'b0, 16'sd0, 1'b1);
      check(qh == qt, "R2 all vectors delivered", longint'(qh), longint'(qt));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule